// File: doc/BRIEF.md
# Wall-Following Step Controller

This block steers a maze-walking robot that keeps its right feeler pressed against a wall. Two contact inputs report whether the left and right feelers are touching something. Three command outputs ask the drive to take one step forward, to make a small turn to the left, or to make a small turn to the right. All decisions come from a 16-word constant lookup table. The table is addressed by the 2-bit registered state followed by the left and then the right contact bit. Each word holds the next state and the three commands.

The controller has four states. In `seek` it walks straight until it bumps into something. In `spin` it rotates left on the spot until both feelers are clear. The two hugging states, `hug_a` and `hug_b`, alternate between curving right toward the wall and curving left away from it. The state register moves only on clock edges where the step-enable input is high. The drive logic therefore sets the pace, and one step is taken per enabled edge. The commands are decoded from the state currently held in the register.

Top module: `wall_follow_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the state in `seek` (state_o = 2'b00), and the outputs are then fwd=1, turn_l=0, turn_r=0.
- R2: On an edge with step_en low and rst low, the state is left unchanged, whatever the contact inputs are.
- R3: In `seek` (2'b00) the outputs are fwd=1, turn_l=0, turn_r=0. An enabled step with both contacts low stays in `seek`. An enabled step with either contact high goes to `spin` (2'b01).
- R4: In `spin` (2'b01) the outputs are fwd=0, turn_l=1, turn_r=0. An enabled step with either contact high stays in `spin`. An enabled step with both contacts low goes to `hug_a` (2'b10).
- R5: In `hug_a` (2'b10) the outputs are fwd=1, turn_l=0, turn_r=1. An enabled step goes to `hug_b` (2'b11) when touch_r is high and stays in `hug_a` when touch_r is low. touch_l has no effect in this state.
- R6: In `hug_b` (2'b11) the outputs are fwd=1, turn_l=1, turn_r=0. An enabled step goes to `spin` if touch_l is high. It goes to `hug_a` if both contacts are low. It stays in `hug_b` if only touch_r is high.
- R7: The command outputs depend only on the registered state. Changing the contacts without an enabled step leaves fwd, turn_l and turn_r unchanged.
- R8: turn_l and turn_r are never high together.
- R9: The state is encoded as seek=00, spin=01, hug_a=10, hug_b=11. This encoding is visible on state_o, and the table address is {state, touch_l, touch_r}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Enables a state update on this edge |
| touch_l | input | 1 | Left feeler contact, high when touching |
| touch_r | input | 1 | Right feeler contact, high when touching |
| state_o | output | 2 | Registered controller state |
| fwd | output | 1 | Step forward command |
| turn_l | output | 1 | Small left turn command |
| turn_r | output | 1 | Small right turn command |

## Verification
A new state shows on state_o after exactly one clock edge: the first edge at which step_en is high. The commands follow with no further cycle, because they are decoded combinationally from that register. The bench changes the contacts and the enable at the falling edge and samples all outputs at the following falling edge, half a cycle after the updating edge. For each of the 16 table addresses, the expected next state is computed from closed-form equations for the next state. The expected commands are computed from the equations for the outputs as a function of state.

// File: rtl/wf_pkg.sv
package wf_pkg;

  localparam int WF_STATE_W = 2;
  localparam int WF_SENSE_W = 2;
  localparam int WF_ADDR_W  = WF_STATE_W + WF_SENSE_W;
  localparam int WF_CMD_W   = 3;
  localparam int WF_WORD_W  = WF_STATE_W + WF_CMD_W;

  typedef enum logic [WF_STATE_W-1:0] {
    ST_SEEK  = 2'b00,
    ST_SPIN  = 2'b01,
    ST_HUG_A = 2'b10,
    ST_HUG_B = 2'b11
  } wf_state_e;

  // word layout: {next state, turn right, turn left, forward}
  typedef struct packed {
    logic [WF_STATE_W-1:0] nxt;
    logic                  tr;
    logic                  tl;
    logic                  fwd;
  } wf_word_t;

  // Policy for one table address {state, left, right}.
  function automatic wf_word_t wf_entry(input logic [WF_ADDR_W-1:0] adr);
    wf_word_t  w;
    wf_state_e s;
    logic      lf;
    logic      rt;
    s  = wf_state_e'(adr[WF_ADDR_W-1:WF_SENSE_W]);
    lf = adr[1];
    rt = adr[0];
    w  = '0;
    case (s)
      ST_SEEK: begin
        w.fwd = 1'b1;
        w.nxt = (lf || rt) ? ST_SPIN : ST_SEEK;
      end
      ST_SPIN: begin
        w.tl  = 1'b1;
        w.nxt = (lf || rt) ? ST_SPIN : ST_HUG_A;
      end
      ST_HUG_A: begin
        w.fwd = 1'b1;
        w.tr  = 1'b1;
        w.nxt = rt ? ST_HUG_B : ST_HUG_A;
      end
      default: begin
        w.fwd = 1'b1;
        w.tl  = 1'b1;
        if (lf)      w.nxt = ST_SPIN;
        else if (rt) w.nxt = ST_HUG_B;
        else         w.nxt = ST_HUG_A;
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/wf_table.sv
module wf_table
  import wf_pkg::*;
#(
  parameter int ADDR_W = WF_ADDR_W,
  parameter int WORD_W = WF_WORD_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] tbl [DEPTH];

  // Constant contents, one word per address, computed from the policy.
  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign tbl[i] = WORD_W'(wf_entry(WF_ADDR_W'(i)));
  end

  assign word = tbl[addr];

endmodule

// File: rtl/wf_state_reg.sv
module wf_state_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  // R1: reset lands in seek
  a_r1_reset_seek: assert property (@(posedge clk) rst |=> (q == '0));

  // R2: no enable, no movement
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

endmodule

// File: rtl/wall_follow_ctrl.sv
module wall_follow_ctrl
  import wf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_en,
  input  logic                  touch_l,
  input  logic                  touch_r,
  output logic [WF_STATE_W-1:0] state_o,
  output logic                  fwd,
  output logic                  turn_l,
  output logic                  turn_r
);

  logic [WF_STATE_W-1:0] cur_q;
  logic [WF_ADDR_W-1:0]  tbl_addr;
  logic [WF_WORD_W-1:0]  tbl_word;
  wf_word_t              entry;

  assign tbl_addr = {cur_q, touch_l, touch_r};

  wf_table #(
    .ADDR_W(WF_ADDR_W),
    .WORD_W(WF_WORD_W)
  ) u_table (
    .addr(tbl_addr),
    .word(tbl_word)
  );

  assign entry = wf_word_t'(tbl_word);

  wf_state_reg #(
    .W(WF_STATE_W)
  ) u_state (
    .clk(clk),
    .rst(rst),
    .en (step_en),
    .d  (entry.nxt),
    .q  (cur_q)
  );

  assign state_o = cur_q;
  assign fwd     = entry.fwd;
  assign turn_l  = entry.tl;
  assign turn_r  = entry.tr;

  // R8: never both turns
  a_r8_one_turn: assert property (@(posedge clk) disable iff (rst)
    !(turn_l && turn_r));

  // R4: spinning never steps
  a_r4_spin_still: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01) |-> (!fwd && turn_l));

  // R3: seek with a contact and an enabled step goes to spin
  a_r3_seek_bump: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == 2'b00 && (touch_l || touch_r)) |=> (state_o == 2'b01));

  // R6: hug_b with left contact and an enabled step returns to spin
  a_r6_hugb_left: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == 2'b11 && touch_l) |=> (state_o == 2'b01));

  // R5: hug_a with no right contact and an enabled step stays put
  a_r5_huga_stay: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == 2'b10 && !touch_r) |=> (state_o == 2'b10));

endmodule

// File: tb/wall_follow_ctrl_test.sv
module wall_follow_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       touch_l = 1'b0;
  logic       touch_r = 1'b0;
  logic [1:0] state_o;
  logic       fwd, turn_l, turn_r;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wall_follow_ctrl uut (
    .clk(clk), .rst(rst), .step_en(step_en),
    .touch_l(touch_l), .touch_r(touch_r),
    .state_o(state_o), .fwd(fwd), .turn_l(turn_l), .turn_r(turn_r)
  );

  // Table addresses visited, in a scrambled order: {state, L, R}.
  localparam logic [3:0] VISIT [16] = '{
    4'hB, 4'h0, 4'h6, 4'hF, 4'h3, 4'h8, 4'hD, 4'h5,
    4'h1, 4'hE, 4'h9, 4'h4, 4'hC, 4'h2, 4'hA, 4'h7
  };

  function automatic logic [1:0] exp_next(input logic [1:0] s, input logic l, input logic r);
    logic n1, n0;
    n1 = (s[1] & (~s[0] | ~l)) | (~s[1] & s[0] & ~l & ~r);
    n0 = r | (l & (~s[1] | s[0]));
    return {n1, n0};
  endfunction

  function automatic logic [2:0] exp_cmd(input logic [1:0] s);
    // {fwd, turn_l, turn_r}
    return {s[1] | ~s[0], s[0], s[1] & ~s[0]};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic r, input logic en);
    @(negedge clk);
    touch_l = l; touch_r = r; step_en = en;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Walk from reset to state s using only enabled steps.
  task automatic goto_state(input logic [1:0] s);
    do_reset();
    if (s != 2'b00) step(1'b1, 1'b0, 1'b1);   // seek -> spin
    if (s[1])       step(1'b0, 1'b0, 1'b1);   // spin -> hug_a
    if (s == 2'b11) step(1'b0, 1'b1, 1'b1);   // hug_a -> hug_b
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] held;
    logic [2:0] cmd;
    // R1, R9: reset state
    do_reset();
    check("R1", {state_o, fwd, turn_l, turn_r}, {2'b00, 3'b100});

    // R3 R4 R5 R6 R9: every table address against the closed-form equations
    for (int k = 0; k < 16; k++) begin
      logic [1:0] s;
      logic l, r;
      s = VISIT[k][3:2]; l = VISIT[k][1]; r = VISIT[k][0];
      goto_state(s);
      check("R9", {state_o, 3'b000}, {s, 3'b000});
      check(s == 2'b00 ? "R3" : s == 2'b01 ? "R4" : s == 2'b10 ? "R5" : "R6",
            {state_o, fwd, turn_l, turn_r}, {s, exp_cmd(s)});
      step(l, r, 1'b1);
      check(s == 2'b00 ? "R3" : s == 2'b01 ? "R4" : s == 2'b10 ? "R5" : "R6",
            {state_o, fwd, turn_l, turn_r}, {exp_next(s, l, r), exp_cmd(exp_next(s, l, r))});
      check("R8", {4'b0000, turn_l & turn_r}, 5'b00000);
    end

    // R2, R7: contacts toggling without enable leave state and commands alone
    for (int s = 0; s < 4; s++) begin
      goto_state(2'(s));
      held = state_o;
      cmd  = {fwd, turn_l, turn_r};
      for (int v = 0; v < 4; v++) begin
        step(v[1], v[0], 1'b0);
        check("R2", {state_o, 3'b000}, {held, 3'b000});
        check("R7", {2'b00, fwd, turn_l, turn_r}, {2'b00, cmd});
      end
    end

    // R5: left contact ignored in hug_a
    goto_state(2'b10);
    step(1'b1, 1'b0, 1'b1);
    check("R5", {state_o, fwd, turn_l, turn_r}, {2'b10, 3'b101});

    // R1: reset wins over an enabled step
    goto_state(2'b11);
    @(negedge clk);
    rst = 1'b1; step_en = 1'b1; touch_l = 1'b1;
    @(negedge clk);
    rst = 1'b0; step_en = 1'b0;
    check("R1", {state_o, fwd, turn_l, turn_r}, {2'b00, 3'b100});

    // R6: long run along a wall, hug_b -> hug_b -> hug_a -> hug_b -> spin
    goto_state(2'b11);
    step(1'b0, 1'b1, 1'b1);
    check("R6", {state_o, 3'b000}, {2'b11, 3'b000});
    step(1'b0, 1'b0, 1'b1);
    check("R6", {state_o, 3'b000}, {2'b10, 3'b000});
    step(1'b0, 1'b1, 1'b1);
    check("R5", {state_o, 3'b000}, {2'b11, 3'b000});
    step(1'b1, 1'b1, 1'b1);
    check("R6", {state_o, fwd, turn_l, turn_r}, {2'b01, 3'b010});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule